// File: doc/BRIEF.md
# DRAM Strobe-Sequence Cycle Decoder

This block is a device-side behavioural model of a small page-mode DRAM. It samples the row strobe, column strobe, write enable and output enable pins on a fast system clock. From the order of their edges it classifies every row-strobe cycle into one of four kinds: a refresh addressed from the pins, a refresh addressed by an internal counter, an entry into a compressed test mode, or a normal access. Each classification is reported as a one-clock event carrying a kind code and a row number. Accesses use a small internal array that can be covered exhaustively by a bench.

Within an access cycle, each column-strobe fall is either a read or a write. A write enable already low at the column fall means an early write, and the outputs stay released. A write-enable fall after read data is out means a read-modify-write, which writes the pins' data to the same column. Read data is extended past the column strobe's rise.

While the latched test flag is set, a write stores each data bit into a group of 8 cells. A read returns, per data bit, whether all 8 cells of its group agree. A memory tester can therefore check 32 cells per access.

Top module: `dram_strobe_decoder`

## Requirements
- R1: A row-strobe fall sampled while the column strobe is low and write enable is high reports kind 2 (counter refresh), with cyc_row equal to an internal counter. The counter starts at 0 after reset and advances by one on each kind 2 or kind 3 event.
- R2: A row-strobe fall sampled while both column strobe and write enable are low reports kind 3 (test entry), with the counter row, and sets test_mode.
- R3: A row-strobe fall with the column strobe high, followed by a row-strobe rise with no column-strobe fall in between, reports kind 1 (pin-addressed refresh), with cyc_row equal to the address sampled at the row-strobe fall.
- R4: test_mode is cleared by a kind 1 event or a kind 2 event, and is left unchanged by reads and writes.
- R5: A column-strobe fall in an access cycle with write enable high reports kind 4 (read) and loads dq_o with the word at (latched row, sampled column). dq_oe is high while that data is held and oe_n is low. The data stays driven after the column strobe rises, and is released once both strobes are high.
- R6: A column-strobe fall with write enable already low reports kind 5 (early write) and stores dq_i at (row, column). dq_oe stays low throughout.
- R7: A write-enable fall while the column strobe is low after a read reports kind 6 (read-modify-write). It stores dq_i at the column of that read and releases dq_oe.
- R8: In test mode, a write ignores column bits 0 and 1 and row bit 0. Data bit k is stored into bit k of all 8 cells of the selected group.
- R9: In test mode, a read drives bit k of dq_o to 1 when bit k of all 8 cells of the group is equal, and to 0 otherwise.
- R10: Several column-strobe pulses within one row-strobe low period each perform an access at their own column, all in the latched row.
- R11: After reset, test_mode, dq_oe and cyc_valid are 0 and every array cell holds 0.
- R12: Cycling the row strobe while the column strobe is held low after a read performs a kind 2 refresh, and the read data stays driven on dq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DQ_W | Write data from the pins |
| dq_o | output | DQ_W | Read data (or test compare result) |
| dq_oe | output | 1 | Drive enable for dq_o |
| test_mode | output | 1 | Latched compressed test flag |
| cyc_valid | output | 1 | One-clock pulse marking a classified event |
| cyc_kind | output | 3 | Event kind: 1 pin refresh, 2 counter refresh, 3 test entry, 4 read, 5 early write, 6 read-modify-write |
| cyc_row | output | ADDR_W | Row of the event |

## Verification
A counter refresh and a read can be in progress together. This is the hidden refresh: the column strobe is held low after a read while the row strobe is raised and lowered again. The bench provokes it by expecting a kind 2 event with the next counter row in its scoreboard. It also checks that dq_oe and dq_o keep the read word through both row-strobe edges and drop only when the column strobe finally rises. A second overlap comes from a write-enable fall inside a read. The bench checks that this single pin edge both stops the drive and commits a write, and it reads the new word back afterwards.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_CBR  = 2'd2
    } phase_e;

    localparam logic [2:0] KIND_NONE  = 3'd0;
    localparam logic [2:0] KIND_RONLY = 3'd1;
    localparam logic [2:0] KIND_CBR   = 3'd2;
    localparam logic [2:0] KIND_TMENT = 3'd3;
    localparam logic [2:0] KIND_READ  = 3'd4;
    localparam logic [2:0] KIND_EWR   = 3'd5;
    localparam logic [2:0] KIND_RMW   = 3'd6;

endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge
    import dram_strobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t pins,
    output strobe_t cur,
    output logic    ras_fall,
    output logic    ras_rise,
    output logic    cas_fall,
    output logic    cas_rise,
    output logic    we_fall
);

    typedef struct packed {
        strobe_t cur;
        logic    ras_p;
        logic    cas_p;
        logic    we_p;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cur   = pins;
        st_d.ras_p = st_q.cur.ras_n;
        st_d.cas_p = st_q.cur.cas_n;
        st_d.we_p  = st_q.cur.we_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur      = st_q.cur;
    assign ras_fall = st_q.ras_p & ~st_q.cur.ras_n;
    assign ras_rise = ~st_q.ras_p & st_q.cur.ras_n;
    assign cas_fall = st_q.cas_p & ~st_q.cur.cas_n;
    assign cas_rise = ~st_q.cas_p & st_q.cur.cas_n;
    assign we_fall  = st_q.we_p & ~st_q.cur.we_n;

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ADDR_W = 3,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_grp,
    input  logic [ADDR_W-1:0] wr_row,
    input  logic [ADDR_W-1:0] wr_col,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_row,
    input  logic [ADDR_W-1:0] rd_col,
    output logic [DQ_W-1:0]   rd_word,
    output logic [DQ_W-1:0]   rd_cmp
);

    localparam int NROW = 1 << ADDR_W;
    localparam int NCOL = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] ROW_GMASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] COL_GMASK = ADDR_W'(3);

    logic [NROW-1:0][NCOL-1:0][DQ_W-1:0] mem_d, mem_q;

    function automatic logic in_grp(input int r, input int c,
                                    input logic [ADDR_W-1:0] gr,
                                    input logic [ADDR_W-1:0] gc);
        return ((ADDR_W'(r) | ROW_GMASK) == (gr | ROW_GMASK)) &&
               ((ADDR_W'(c) | COL_GMASK) == (gc | COL_GMASK));
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            if (!wr_grp) begin
                mem_d[wr_row][wr_col] = wr_data;
            end else begin
                for (int r = 0; r < NROW; r++) begin
                    for (int c = 0; c < NCOL; c++) begin
                        if (in_grp(r, c, wr_row, wr_col)) begin
                            mem_d[r][c] = wr_data;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_word = mem_q[rd_row][rd_col];

    for (genvar k = 0; k < DQ_W; k++) begin : g_cmp
        logic all_one;
        logic any_one;
        always_comb begin
            all_one = 1'b1;
            any_one = 1'b0;
            for (int r = 0; r < NROW; r++) begin
                for (int c = 0; c < NCOL; c++) begin
                    if (in_grp(r, c, rd_row, rd_col)) begin
                        all_one = all_one & mem_q[r][c][k];
                        any_one = any_one | mem_q[r][c][k];
                    end
                end
            end
        end
        assign rd_cmp[k] = all_one | ~any_one;
    end

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dram_strobe_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_i,
    output logic [DQ_W-1:0]   dq_o,
    output logic              dq_oe,
    output logic              test_mode,
    output logic              cyc_valid,
    output logic [2:0]        cyc_kind,
    output logic [ADDR_W-1:0] cyc_row
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] rcnt;
        logic              tm;
        logic              cas_seen;
        logic              rd_act;
        logic              dvld;
        logic [DQ_W-1:0]   dout;
        logic              ev_vld;
        logic [2:0]        ev_kind;
        logic [ADDR_W-1:0] ev_row;
        logic [ADDR_W-1:0] addr_s;
        logic [DQ_W-1:0]   din_s;
    } dec_st_t;

    dec_st_t st_d, st_q;

    strobe_t pins, cur;
    logic    ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_col;
    logic [DQ_W-1:0]   rd_word, rd_cmp;

    assign pins = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};

    dram_strobe_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins),
        .cur      (cur),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall),
        .cas_rise (cas_rise),
        .we_fall  (we_fall)
    );

    dram_cell_array #(
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W)
    ) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_grp  (st_q.tm),
        .wr_row  (st_q.row),
        .wr_col  (wr_col),
        .wr_data (st_q.din_s),
        .rd_row  (st_q.row),
        .rd_col  (st_q.addr_s),
        .rd_word (rd_word),
        .rd_cmp  (rd_cmp)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ev_vld  = 1'b0;
        st_d.ev_kind = KIND_NONE;
        st_d.addr_s  = addr;
        st_d.din_s   = dq_i;
        wr_en        = 1'b0;
        wr_col       = st_q.col;

        if (ras_fall) begin
            if (!cur.cas_n) begin
                // column strobe already low: refresh from the counter
                st_d.phase  = PH_CBR;
                st_d.ev_vld = 1'b1;
                st_d.ev_row = st_q.rcnt;
                st_d.rcnt   = st_q.rcnt + 1'b1;
                if (!cur.we_n) begin
                    st_d.tm      = 1'b1;
                    st_d.ev_kind = KIND_TMENT;
                end else begin
                    st_d.tm      = 1'b0;
                    st_d.ev_kind = KIND_CBR;
                end
            end else begin
                st_d.phase    = PH_ROW;
                st_d.row      = st_q.addr_s;
                st_d.cas_seen = 1'b0;
                st_d.rd_act   = 1'b0;
            end
        end else if (ras_rise) begin
            if (st_q.phase == PH_ROW && !st_q.cas_seen) begin
                st_d.ev_vld  = 1'b1;
                st_d.ev_kind = KIND_RONLY;
                st_d.ev_row  = st_q.row;
                st_d.tm      = 1'b0;
            end
            st_d.phase  = PH_IDLE;
            st_d.rd_act = 1'b0;
            if (cur.cas_n) begin
                st_d.dvld = 1'b0;
            end
        end else if (st_q.phase == PH_ROW) begin
            if (cas_fall) begin
                st_d.cas_seen = 1'b1;
                st_d.col      = st_q.addr_s;
                st_d.ev_vld   = 1'b1;
                st_d.ev_row   = st_q.row;
                if (!cur.we_n) begin
                    st_d.ev_kind = KIND_EWR;
                    wr_en        = 1'b1;
                    wr_col       = st_q.addr_s;
                    st_d.dvld    = 1'b0;
                    st_d.rd_act  = 1'b0;
                end else begin
                    st_d.ev_kind = KIND_READ;
                    st_d.dvld    = 1'b1;
                    st_d.dout    = st_q.tm ? rd_cmp : rd_word;
                    st_d.rd_act  = 1'b1;
                end
            end else if (we_fall) begin
                if (!cur.cas_n && st_q.rd_act) begin
                    st_d.ev_vld  = 1'b1;
                    st_d.ev_kind = KIND_RMW;
                    st_d.ev_row  = st_q.row;
                    wr_en        = 1'b1;
                    st_d.rd_act  = 1'b0;
                end
                st_d.dvld = 1'b0;
            end else if (cas_rise) begin
                st_d.rd_act = 1'b0;
            end
        end else begin
            if (cas_rise && cur.ras_n) begin
                st_d.dvld = 1'b0;
            end
            if (we_fall) begin
                st_d.dvld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o      = st_q.dout;
    assign dq_oe     = st_q.dvld & ~cur.oe_n;
    assign test_mode = st_q.tm;
    assign cyc_valid = st_q.ev_vld;
    assign cyc_kind  = st_q.ev_kind;
    assign cyc_row   = st_q.ev_row;

endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_valid,
    input logic [2:0] cyc_kind,
    input logic       test_mode,
    input logic       dq_oe
);

    AST_EWR_KEEPS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 3'd5) |-> !dq_oe);  // R6

    AST_RMW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 3'd6) |-> !dq_oe);  // R7

    AST_TM_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_kind == 3'd3) |-> test_mode);  // R2

    AST_TM_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_kind == 3'd1 || cyc_kind == 3'd2)) |-> !test_mode);  // R4

    AST_TM_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode != $past(test_mode)) |-> (cyc_valid && cyc_kind <= 3'd3));  // R4

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_kind >= 3'd1 && cyc_kind <= 3'd6));  // R1

endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_kind  (cyc_kind),
    .test_mode (test_mode),
    .dq_oe     (dq_oe)
);

// File: tb/dram_strobe_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int DW = 4;
    localparam int NR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe, test_mode, cyc_valid;
    logic [2:0]    cyc_kind;
    logic [AW-1:0] cyc_row;

    int n_cmp = 0;
    int n_bad = 0;
    logic [5:0] exp_q[$];
    logic [DW-1:0] ref_mem [NR][NR];
    logic          ref_tm = 1'b0;
    logic [AW-1:0] ref_rcnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(AW), .DQ_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .test_mode(test_mode), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
        .cyc_row(cyc_row)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic tick(input int n = 3);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_ev(input logic [2:0] k, input logic [AW-1:0] r);
        exp_q.push_back({k, r});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected event actual=%0h expected=none", {cyc_kind, cyc_row});
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                if ({cyc_kind, cyc_row} !== e) begin
                    n_bad++;
                    $display("FAIL R1/R3/R5 event kind,row actual=%0h expected=%0h",
                             {cyc_kind, cyc_row}, e);
                end
            end
        end
    end

    function automatic logic in_grp(input int r, input int c, input int gr, input int gc);
        return ((r | 1) == (gr | 1)) && ((c | 3) == (gc | 3));
    endfunction

    function automatic logic [DW-1:0] exp_read(input int r, input int c);
        logic [DW-1:0] res;
        if (!ref_tm) return ref_mem[r][c];
        for (int k = 0; k < DW; k++) begin
            int ones = 0;
            for (int rr = 0; rr < NR; rr++)
                for (int cc = 0; cc < NR; cc++)
                    if (in_grp(rr, cc, r, c) && ref_mem[rr][cc][k]) ones++;
            res[k] = (ones == 0) || (ones == 8);
        end
        return res;
    endfunction

    task automatic ref_write(input int r, input int c, input logic [DW-1:0] d);
        if (!ref_tm) ref_mem[r][c] = d;
        else
            for (int rr = 0; rr < NR; rr++)
                for (int cc = 0; cc < NR; cc++)
                    if (in_grp(rr, cc, r, c)) ref_mem[rr][cc] = d;
    endtask

    task automatic early_write(input int r, input int c, input logic [DW-1:0] d);
        push_ev(3'd5, AW'(r));
        addr = AW'(r); ras_n = 0; tick();
        addr = AW'(c); dq_i = d; we_n = 0; oe_n = 0; tick();
        cas_n = 0; tick();
        chk("R6 early write keeps dq_oe low", dq_oe, 0);
        cas_n = 1; tick();
        we_n = 1; ras_n = 1; oe_n = 1; tick();
        ref_write(r, c, d);
    endtask

    task automatic read_word(input string tag, input int r, input int c);
        logic [DW-1:0] e;
        e = exp_read(r, c);
        push_ev(3'd4, AW'(r));
        addr = AW'(r); ras_n = 0; tick();
        addr = AW'(c); oe_n = 0; cas_n = 0; tick();
        chk({tag, " dq_oe"}, dq_oe, 1);
        chk({tag, " dq_o"}, dq_o, e);
        cas_n = 1; ras_n = 1; tick();
        oe_n = 1; tick();
    endtask

    task automatic ras_only(input int r);
        push_ev(3'd1, AW'(r));
        addr = AW'(r); ras_n = 0; tick();
        ras_n = 1; tick();
        ref_tm = 0;
    endtask

    task automatic cbr(input logic we_low);
        push_ev(we_low ? 3'd3 : 3'd2, ref_rcnt);
        ref_rcnt = ref_rcnt + 1'b1;
        cas_n = 0; we_n = ~we_low; tick();
        ras_n = 0; tick();
        ras_n = 1; tick();
        cas_n = 1; we_n = 1; tick();
        ref_tm = we_low;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NR; c++) ref_mem[r][c] = '0;
        tick(4);
        rst_n = 1;
        tick(2);
        // R11 reset state
        chk("R11 test_mode after reset", test_mode, 0);
        chk("R11 dq_oe after reset", dq_oe, 0);
        chk("R11 cyc_valid after reset", cyc_valid, 0);
        read_word("R11 array zero", 6, 6);

        // R6 early write, then R5 read with extended output
        early_write(1, 5, 4'hA);
        push_ev(3'd4, 3'd1);
        addr = 1; ras_n = 0; tick();
        addr = 5; oe_n = 0; cas_n = 0; tick();
        chk("R5 read drive", dq_oe, 1);
        chk("R5 read data", dq_o, 4'hA);
        cas_n = 1; tick();
        chk("R5 data held after column rise", dq_oe, 1);
        chk("R5 data value after column rise", dq_o, 4'hA);
        oe_n = 1; tick();
        chk("R5 oe high releases", dq_oe, 0);
        ras_n = 1; tick();
        oe_n = 0; tick();
        chk("R5 released once both strobes high", dq_oe, 0);
        oe_n = 1; tick();

        // R10 page mode: writes then reads within one row cycle
        for (int c = 0; c < 4; c++) early_write(2, c, DW'(c + 3));
        addr = 2; ras_n = 0; tick();
        oe_n = 0;
        for (int c = 0; c < 4; c++) begin
            push_ev(3'd4, 3'd2);
            addr = AW'(c); cas_n = 0; tick();
            chk("R10 page read data", dq_o, DW'(c + 3));
            cas_n = 1; tick();
        end
        ras_n = 1; oe_n = 1; tick();

        // R7 read-modify-write
        early_write(3, 2, 4'h5);
        push_ev(3'd4, 3'd3);
        push_ev(3'd6, 3'd3);
        addr = 3; ras_n = 0; tick();
        addr = 2; oe_n = 0; cas_n = 0; tick();
        chk("R7 read phase data", dq_o, 4'h5);
        dq_i = 4'hC; we_n = 0; tick();
        chk("R7 write enable releases drive", dq_oe, 0);
        cas_n = 1; ras_n = 1; we_n = 1; oe_n = 1; tick();
        ref_write(3, 2, 4'hC);
        read_word("R7 read back", 3, 2);

        // R3 pin refresh, R1 counter refresh
        ras_only(2);
        cbr(1'b0);
        cbr(1'b0);

        // R2 test entry and R9 compare with mismatching cells
        early_write(0, 4, 4'h3);
        cbr(1'b1);
        chk("R2 test_mode set", test_mode, 1);
        read_word("R9 compare mixed group", 1, 7);
        // R8 group write then compare
        early_write(1, 5, 4'hA);
        read_word("R9 compare uniform group", 0, 6);
        chk("R4 access leaves test_mode", test_mode, 1);
        ras_only(0);
        chk("R4 pin refresh clears test_mode", test_mode, 0);
        read_word("R8 replicated cell", 0, 7);
        read_word("R8 replicated other row", 1, 4);
        read_word("R8 outside group untouched", 3, 2);
        cbr(1'b1);
        chk("R2 test_mode set again", test_mode, 1);
        cbr(1'b0);
        chk("R4 counter refresh clears test_mode", test_mode, 0);

        // R12 hidden refresh during a read
        push_ev(3'd4, 3'd1);
        addr = 1; ras_n = 0; tick();
        addr = 5; oe_n = 0; cas_n = 0; tick();
        ras_n = 1; tick();
        chk("R12 drive after row rise", dq_oe, 1);
        push_ev(3'd2, ref_rcnt);
        ref_rcnt = ref_rcnt + 1'b1;
        ras_n = 0; tick();
        chk("R12 drive during refresh", dq_oe, 1);
        chk("R12 data during refresh", dq_o, 4'hA);
        ras_n = 1; tick();
        cas_n = 1; tick();
        chk("R12 released at column rise", dq_oe, 0);
        oe_n = 1; tick();

        chk("R1 all expected events seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule